// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Fast Path

This block collects a set of on-chip peripheral interrupt lines and a small number of external interrupt pins and merges them into one normal interrupt request. Each source has its own configuration word: an enable (mask) bit, a trigger selection and a 3-bit priority. Among the sources that are pending and enabled, a priority encoder picks the one with the highest level and reports its index. The host clears an edge-latched request by acknowledging the source that is currently reported.

A separate fast interrupt output is fed only by one dedicated external pin. It has its own enable and no path from the normal sources. External inputs are asynchronous to the clock and pass through a two-flop synchroniser. Internal sources are already synchronous and are used directly. External sources offer four trigger types. Internal sources offer only a level or an edge, both of positive polarity.

Source indices run from 0 to N_INT-1 for the internal lines, followed by N_INT to N_INT+N_EXT-1 for the external pins. With the default parameters there are 6 internal and 2 external sources.

Top module: `pic_top`

## Requirements
- R1: After reset, irq_o, fiq_o and irq_id_o are 0. Every source configuration word reads 0, which means disabled, high-level trigger and priority 0. The fast enable reads 0.
- R2: Configuration address i (0..N_SRC-1) holds source i's word: bits [2:0] priority (7 is highest), bits [4:3] trigger, bit 5 enable. A write takes effect at the clock edge, and the word reads back on cfg_rdata_o through a combinational read path. For an internal source, bit 4 is not stored and reads 0.
- R3: Trigger codes for external sources are 00 high level, 01 rising edge, 10 low level and 11 falling edge. Internal sources use only bit 3: 0 selects high level and 1 selects rising edge.
- R4: irq_id_o reports the enabled, pending source with the highest priority. When priorities are equal, the lower index wins. A priority-0 source still raises a request.
- R5: irq_o is 1 exactly when some enabled source is pending. While it is 0, irq_id_o is 0. Both outputs are registered. An internal level change shows up one edge after it is sampled. An external level change shows up three edges after it is applied.
- R6: An edge-triggered source latches its pending bit even while it is disabled. Enabling the source afterwards raises the request.
- R7: When ack_i is high at an edge while irq_o is 1, the pending bit of the source in irq_id_o is cleared. A level source is unaffected by the acknowledge and stays requested while its input is active.
- R8: fiq_o equals the synchronised fast pin ANDed with the fast enable (address N_SRC+1, bit 0). It rises three edges after the pin is applied. No normal source drives it, and the fast pin does not drive irq_o.
- R9: Address N_SRC is a read-only status word. Bit 7 holds irq_o and the low bits hold irq_id_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_src_i | input | N_INT | Internal peripheral interrupt lines (synchronous) |
| ext_src_i | input | N_EXT | External interrupt pins (asynchronous) |
| fiq_pin_i | input | 1 | Dedicated fast interrupt pin (asynchronous) |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | AW | Configuration address |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data |
| ack_i | input | 1 | Acknowledge of the currently reported source |
| irq_o | output | 1 | Normal interrupt request |
| irq_id_o | output | IDW | Index of the winning source |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:
- **Equal priorities.** A design that picked the wrong winner would report index 2 instead of 1.
- **Priority 0.** A design that treated level 0 as "off" would leave irq_o low.
- **Falling-edge and low-level external triggers.** These need correct polarity handling and the three-edge synchroniser latency. A missing or extra flop shows up as a request one cycle early or late.
- **Edge arriving while masked.** A design that dropped the edge would never raise the request once the source is enabled.
- **Acknowledge.** An acknowledge that failed to clear an edge source would keep irq_o high. One that cleared a level source would drop a request whose input is still active.
- **Fast pin.** It must stay gated until its enable is set, and must never light irq_o.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PRIO_W = 3;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_RISE = 2'b01,
    TRIG_LOW  = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  typedef struct packed {
    logic              en;
    trig_e             trig;
    logic [PRIO_W-1:0] prio;
  } src_cfg_t;

  localparam int CFG_W = $bits(src_cfg_t);
endpackage

// File: rtl/pic_src_cond.sv
module pic_src_cond
  import pic_pkg::*;
#(
  parameter bit EXTERNAL = 1'b0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  raw_i,
  input  trig_e trig_i,
  input  logic  clr_i,
  output logic  req_o,
  output logic  set_o,
  output logic  edge_mode_o,
  output logic  pend_o
);
  logic samp, prev_q, pend_q, lvl;

  generate
    if (EXTERNAL) begin : g_sync
      logic s1_q, s2_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          s1_q <= 1'b0;
          s2_q <= 1'b0;
        end else begin
          s1_q <= raw_i;
          s2_q <= s1_q;
        end
      end
      assign samp = s2_q;
    end else begin : g_direct
      assign samp = raw_i;
    end
  endgenerate

  assign edge_mode_o = trig_i[0];
  assign lvl         = trig_i[1] ? ~samp : samp;

  always_comb begin
    unique case (trig_i)
      TRIG_RISE: set_o = samp & ~prev_q;
      TRIG_FALL: set_o = ~samp & prev_q;
      default:   set_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= samp;
      // set beats clear; pending only lives in edge mode
      pend_q <= edge_mode_o & (set_o | (pend_q & ~clr_i));
    end
  end

  assign pend_o = pend_q;
  assign req_o  = edge_mode_o ? pend_q : lvl;
endmodule

// File: rtl/pic_prio_sel.sv
module pic_prio_sel
  import pic_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int IDW   = 3
) (
  input  logic [N_SRC-1:0]        act_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  output logic                    any_o,
  output logic [IDW-1:0]          id_o
);
  logic [PRIO_W-1:0] best_p;

  always_comb begin
    any_o  = 1'b0;
    id_o   = '0;
    best_p = '0;
    for (int i = 0; i < N_SRC; i++) begin
      // strict compare keeps the lower index on a tie
      if (act_i[i] && (!any_o || prio_i[i*PRIO_W +: PRIO_W] > best_p)) begin
        any_o  = 1'b1;
        id_o   = IDW'(i);
        best_p = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
  import pic_pkg::*;
#(
  parameter int N_INT = 6,
  parameter int N_EXT = 2,
  parameter int IDW   = 3,
  parameter int AW    = 4,
  parameter int DW    = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [AW-1:0]              addr_i,
  input  logic [DW-1:0]              wdata_i,
  output logic [DW-1:0]              rdata_o,
  input  logic                       irq_i,
  input  logic [IDW-1:0]             id_i,
  output src_cfg_t [N_INT+N_EXT-1:0] cfg_o,
  output logic                       fiq_en_o
);
  localparam int N_SRC    = N_INT + N_EXT;
  localparam int ADDR_ST  = N_SRC;
  localparam int ADDR_FIQ = N_SRC + 1;

  src_cfg_t [N_SRC-1:0] cfg_q;
  logic                 fiq_en_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic hit;
    assign hit = we_i && (addr_i == AW'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[i] <= '0;
      end else if (hit) begin
        cfg_q[i].en   <= wdata_i[5];
        cfg_q[i].prio <= wdata_i[2:0];
        if (i < N_INT) cfg_q[i].trig <= trig_e'({1'b0, wdata_i[3]});
        else           cfg_q[i].trig <= trig_e'(wdata_i[4:3]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  fiq_en_q <= 1'b0;
    else if (we_i && addr_i == AW'(ADDR_FIQ))     fiq_en_q <= wdata_i[0];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (addr_i == AW'(i)) rdata_o = DW'(cfg_q[i]);
    end
    if (addr_i == AW'(ADDR_ST))  rdata_o = {irq_i, (DW-1-IDW)'(0), id_i};
    if (addr_i == AW'(ADDR_FIQ)) rdata_o = DW'(fiq_en_q);
  end

  assign cfg_o    = cfg_q;
  assign fiq_en_o = fiq_en_q;
endmodule

// File: rtl/pic_top.sv
module pic_top
  import pic_pkg::*;
#(
  parameter int N_INT = 6,
  parameter int N_EXT = 2,
  localparam int N_SRC = N_INT + N_EXT,
  localparam int IDW   = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int AW    = $clog2(N_SRC + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_INT-1:0] int_src_i,
  input  logic [N_EXT-1:0] ext_src_i,
  input  logic             fiq_pin_i,
  input  logic             cfg_we_i,
  input  logic [AW-1:0]    cfg_addr_i,
  input  logic [7:0]       cfg_wdata_i,
  output logic [7:0]       cfg_rdata_o,
  input  logic             ack_i,
  output logic             irq_o,
  output logic [IDW-1:0]   irq_id_o,
  output logic             fiq_o
);
  src_cfg_t [N_SRC-1:0]    cfg_w;
  logic                    fiq_en_w;
  logic [N_SRC-1:0]        raw_w, req_w, act_w, set_w, pend_w, edge_mode_w, clr_w;
  logic [N_SRC*PRIO_W-1:0] prio_w;
  logic                    any_w;
  logic [IDW-1:0]          id_w;
  logic                    irq_q, fiq_s1_q, fiq_s2_q, fiq_q;
  logic [IDW-1:0]          id_q;

  assign raw_w = {ext_src_i, int_src_i};

  pic_cfg_regs #(
    .N_INT(N_INT), .N_EXT(N_EXT), .IDW(IDW), .AW(AW), .DW(8)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .irq_i   (irq_q),
    .id_i    (id_q),
    .cfg_o   (cfg_w),
    .fiq_en_o(fiq_en_w)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_cond
    assign clr_w[i] = ack_i & irq_q & (id_q == IDW'(i));

    pic_src_cond #(.EXTERNAL(i >= N_INT)) u_cond (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .raw_i      (raw_w[i]),
      .trig_i     (cfg_w[i].trig),
      .clr_i      (clr_w[i]),
      .req_o      (req_w[i]),
      .set_o      (set_w[i]),
      .edge_mode_o(edge_mode_w[i]),
      .pend_o     (pend_w[i])
    );

    assign act_w[i]                   = req_w[i] & cfg_w[i].en;
    assign prio_w[i*PRIO_W +: PRIO_W] = cfg_w[i].prio;
  end

  pic_prio_sel #(.N_SRC(N_SRC), .IDW(IDW)) u_sel (
    .act_i (act_w),
    .prio_i(prio_w),
    .any_o (any_w),
    .id_o  (id_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q    <= 1'b0;
      id_q     <= '0;
      fiq_s1_q <= 1'b0;
      fiq_s2_q <= 1'b0;
      fiq_q    <= 1'b0;
    end else begin
      irq_q    <= any_w;
      id_q     <= any_w ? id_w : '0;
      fiq_s1_q <= fiq_pin_i;
      fiq_s2_q <= fiq_s1_q;
      fiq_q    <= fiq_s2_q & fiq_en_w;
    end
  end

  assign irq_o    = irq_q;
  assign irq_id_o = id_q;
  assign fiq_o    = fiq_q;
endmodule

// File: rtl/pic_chk.sv
module pic_chk
  import pic_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int IDW   = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    fiq_pin_i,
  input logic                    fiq_o,
  input logic                    irq_o,
  input logic [IDW-1:0]          irq_id_o,
  input logic                    ack_i,
  input logic [N_SRC-1:0]        act_w,
  input logic [N_SRC*PRIO_W-1:0] prio_w,
  input logic [N_SRC-1:0]        set_w,
  input logic [N_SRC-1:0]        pend_w,
  input logic [N_SRC-1:0]        edge_mode_w
);
  logic [N_SRC-1:0]        act_q;
  logic [N_SRC*PRIO_W-1:0] prio_q;
  logic [PRIO_W-1:0]       sel_p;
  logic                    better;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      prio_q <= '0;
    end else begin
      act_q  <= act_w;
      prio_q <= prio_w;
    end
  end

  always_comb begin
    sel_p = '0;
    for (int i = 0; i < N_SRC; i++)
      if (irq_id_o == IDW'(i)) sel_p = prio_q[i*PRIO_W +: PRIO_W];
    better = 1'b0;
    for (int i = 0; i < N_SRC; i++)
      if (act_q[i] && (prio_q[i*PRIO_W +: PRIO_W] > sel_p ||
          (prio_q[i*PRIO_W +: PRIO_W] == sel_p && IDW'(i) < irq_id_o)))
        better = 1'b1;
  end

  a_r4_winner_is_best: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (act_q[irq_id_o] && !better));

  a_r5_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (irq_id_o == '0 && act_q == '0));

  a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && edge_mode_w[irq_id_o] && !set_w[irq_id_o])
      |=> !pend_w[$past(irq_id_o)]);

  a_r8_fiq_from_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> $past(fiq_pin_i, 3));
endmodule

bind pic_top pic_chk #(.N_SRC(N_SRC), .IDW(IDW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fiq_pin_i  (fiq_pin_i),
  .fiq_o      (fiq_o),
  .irq_o      (irq_o),
  .irq_id_o   (irq_id_o),
  .ack_i      (ack_i),
  .act_w      (act_w),
  .prio_w     (prio_w),
  .set_w      (set_w),
  .pend_w     (pend_w),
  .edge_mode_w(edge_mode_w)
);

// File: tb/pic_top_tb.sv
module pic_top_tb_top;
  localparam int N_INT = 6;
  localparam int N_EXT = 2;
  localparam int N_SRC = N_INT + N_EXT;
  localparam int IDW   = 3;
  localparam int AW    = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [N_INT-1:0] int_src_i = '0;
  logic [N_EXT-1:0] ext_src_i = '0;
  logic             fiq_pin_i = 1'b0;
  logic             cfg_we_i = 1'b0;
  logic [AW-1:0]    cfg_addr_i = '0;
  logic [7:0]       cfg_wdata_i = '0;
  logic [7:0]       cfg_rdata_o;
  logic             ack_i = 1'b0;
  logic             irq_o;
  logic [IDW-1:0]   irq_id_o;
  logic             fiq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk_i = ~clk_i;

  pic_top #(.N_INT(N_INT), .N_EXT(N_EXT)) dut_i (.*);

  // {int_src[5:0], exp_irq, exp_id[2:0]}; priorities 3,5,5,1,7,0
  localparam logic [9:0] VEC [10] = '{
    {6'b000000, 1'b0, 3'd0},
    {6'b000001, 1'b1, 3'd0},
    {6'b000011, 1'b1, 3'd1},
    {6'b000110, 1'b1, 3'd1},
    {6'b000100, 1'b1, 3'd2},
    {6'b010111, 1'b1, 3'd4},
    {6'b101000, 1'b1, 3'd3},
    {6'b100000, 1'b1, 3'd5},
    {6'b111111, 1'b1, 3'd4},
    {6'b001001, 1'b1, 3'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    cfg_we_i = 1'b1; cfg_addr_i = AW'(a); cfg_wdata_i = d;
    step();
    cfg_we_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    cfg_addr_i = AW'(a);
    #1 d = cfg_rdata_o;
  endtask

  task automatic clear_all();
    for (int i = 0; i < N_SRC; i++) wr(i, 8'h00);
    step(2);
  endtask

  initial begin
    logic [7:0] rv;
    step(2);
    rst_ni = 1'b1;
    step();
    // R1
    chk("R1 irq", irq_o, 0);
    chk("R1 fiq", fiq_o, 0);
    chk("R1 id", irq_id_o, 0);
    rd(0, rv); chk("R1 cfg0", rv, 0);
    rd(N_SRC + 1, rv); chk("R1 fiq_en", rv, 0);

    // R4 R5 table walk, internal high-level sources
    wr(0, 8'h23); wr(1, 8'h25); wr(2, 8'h25);
    wr(3, 8'h21); wr(4, 8'h27); wr(5, 8'h20);
    for (int k = 0; k < 10; k++) begin
      int_src_i = VEC[k][9:4];
      step();
      chk($sformatf("R4 vec%0d irq", k), irq_o, VEC[k][3]);
      chk($sformatf("R4 vec%0d id", k), irq_id_o, VEC[k][2:0]);
    end
    int_src_i = '0;
    clear_all();
    chk("R5 idle irq", irq_o, 0);

    // R2 R3 readback
    wr(0, 8'h3F); rd(0, rv); chk("R2 internal drops bit4", rv, 8'h2F);
    wr(6, 8'h3F); rd(6, rv); chk("R2 external full word", rv, 8'h3F);
    clear_all();

    // R3 R7 internal rising edge, prio 6, then ack
    wr(3, 8'h2E);
    int_src_i[3] = 1'b1; step();
    int_src_i[3] = 1'b0; step();
    chk("R3 edge latched irq", irq_o, 1);
    chk("R3 edge latched id", irq_id_o, 3);
    step(3);
    chk("R3 edge held", irq_o, 1);
    ack_i = 1'b1; step(); ack_i = 1'b0;
    chk("R7 ack registered lag", irq_o, 1);
    step();
    chk("R7 ack cleared edge", irq_o, 0);

    // R7 level source survives ack
    wr(0, 8'h21);
    int_src_i[0] = 1'b1; step();
    chk("R7 level irq", irq_o, 1);
    ack_i = 1'b1; step(); ack_i = 1'b0; step();
    chk("R7 level kept", irq_o, 1);
    chk("R7 level id", irq_id_o, 0);
    int_src_i[0] = 1'b0;
    clear_all();

    // R6 masked edge latches
    wr(3, 8'h0E);
    int_src_i[3] = 1'b1; step();
    int_src_i[3] = 1'b0; step(3);
    chk("R6 masked silent", irq_o, 0);
    wr(3, 8'h2E); step();
    chk("R6 unmask irq", irq_o, 1);
    chk("R6 unmask id", irq_id_o, 3);
    ack_i = 1'b1; step(); ack_i = 1'b0; step();
    chk("R6 after ack", irq_o, 0);
    clear_all();

    // R3 R5 external falling edge on source 6, prio 2
    ext_src_i[0] = 1'b1; step(4);
    wr(6, 8'h3A); step(2);
    chk("R3 fall no edge yet", irq_o, 0);
    ext_src_i[0] = 1'b0; step(3);
    chk("R5 ext edge latency", irq_o, 0);
    step();
    chk("R3 fall irq", irq_o, 1);
    chk("R3 fall id", irq_id_o, 6);
    ack_i = 1'b1; step(); ack_i = 1'b0; step();
    chk("R7 ext ack", irq_o, 0);
    clear_all();

    // R3 R5 external low level on source 7, prio 4
    wr(7, 8'h34); step();
    chk("R3 low lvl irq", irq_o, 1);
    chk("R3 low lvl id", irq_id_o, 7);
    ext_src_i[1] = 1'b1; step(2);
    chk("R5 ext level lag", irq_o, 1);
    step();
    chk("R5 ext level drop", irq_o, 0);
    clear_all();

    // R9 status word
    wr(4, 8'h27);
    int_src_i[4] = 1'b1; step(2);
    rd(N_SRC, rv); chk("R9 status", rv, 8'h84);
    int_src_i[4] = 1'b0;
    clear_all();
    rd(N_SRC, rv); chk("R9 status idle", rv, 8'h00);

    // R8 fast path
    fiq_pin_i = 1'b1; step(4);
    chk("R8 fiq gated", fiq_o, 0);
    chk("R8 pin no irq", irq_o, 0);
    fiq_pin_i = 1'b0; step(4);
    wr(N_SRC + 1, 8'h01);
    fiq_pin_i = 1'b1; step(2);
    chk("R8 fiq lag", fiq_o, 0);
    step();
    chk("R8 fiq on", fiq_o, 1);
    chk("R8 irq untouched", irq_o, 0);
    fiq_pin_i = 1'b0;
    wr(2, 8'h27); int_src_i[2] = 1'b1; step(4);
    chk("R8 source no fiq", fiq_o, 0);
    chk("R8 source irq", irq_o, 1);
    int_src_i = '0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule